// File: doc/BRIEF.md
# Strap-configured host bus decoder

This block sits at the host side of a display controller. While reset is held high it loads a set of option straps from the display-memory data pins. From then on those latched straps decide how host cycles are read. The straps give the host bus width, the register access style, the byte-swap option, the handshake personality and the two address keys. The decoder checks each host cycle against those keys. It raises a register-select strobe for a valid I/O cycle and a display-memory-select strobe for a valid memory cycle.

For each cycle it also runs the host handshake. The handshake is either a wait-style ready line, which holds the host off until the transfer completes, or an acknowledge in the 68000 manner, which tells the host that the transfer is finished. The handshake pin is tri-state on a real board, so it is modelled as an output enable plus a driven value.

The straps are plain inputs. A strap pin that nothing pulls up reads 0, so 0 is the default setting of every option. The block that completes a transfer reports it on `xfer_done`. The register contents, display-memory arbitration and SRAM timing live in other blocks.

Top module: `strap_bus_decoder`

## Requirements
- R1: While `rst` is high, `reg_sel`, `mem_sel` and `hs_oe` are 0, whatever the bus inputs do.
- R2: `strap_pins` is loaded on every rising clock edge with `rst` high and then held until the next reset. Later changes on the pins do not affect the flags. The flags are `bus16` = bit 0, `direct_map` = bit 1, `m68k_mode` = bit 2 and `byte_swap` = bit 3.
- R3: An I/O cycle matches only when `host_addr[9:1]` equals `strap_pins[12:4]`. `host_addr[0]` and the other address bits play no part in the match.
- R4: A memory cycle matches only when `host_addr[19:17]` equals `strap_pins[15:13]`.
- R5: With bit 2 = 0 (wait mode), an I/O cycle needs `io_cs_n` low and at least one of `io_rd_n`/`io_wr_n` low. A memory cycle needs `mem_cs_n` low and at least one of `mem_rd_n`/`mem_wr_n` low.
- R6: With bit 2 = 1 (68000 mode), `io_rd_n` is the address strobe for both kinds of cycle. `mem_rd_n` and `mem_wr_n` have no effect.
- R7: `reg_sel` and `mem_sel` are registered. Each one reflects the match on the inputs at the previous rising edge, and both may be high together.
- R8: In wait mode, ready is driven low (`hs_oe`=1, `hs_val`=0) from the first strobe cycle until `xfer_done` is seen. It is then driven high for exactly one cycle and released (`hs_oe`=0) until the cycle ends.
- R9: In 68000 mode, the acknowledge is released until `xfer_done` is seen during a cycle. It is then driven low from the next output cycle until the cycle ends.
- R10: With no valid cycle, `hs_oe` is 0, and `xfer_done` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Active-high reset; straps are loaded while high |
| strap_pins | input | 16 | Display-memory data pins read as option straps |
| host_addr | input | 20 | Host address |
| io_cs_n | input | 1 | I/O chip select, active low |
| mem_cs_n | input | 1 | Memory chip select, active low |
| io_rd_n | input | 1 | I/O read strobe; address strobe in 68000 mode |
| io_wr_n | input | 1 | I/O write strobe; read/write level in 68000 mode |
| mem_rd_n | input | 1 | Memory read strobe (wait mode only) |
| mem_wr_n | input | 1 | Memory write strobe (wait mode only) |
| xfer_done | input | 1 | Downstream transfer has completed |
| reg_sel | output | 1 | Valid register (I/O) cycle |
| mem_sel | output | 1 | Valid display-memory cycle |
| bus16 | output | 1 | Latched 16-bit host bus option |
| direct_map | output | 1 | Latched direct register mapping option |
| m68k_mode | output | 1 | Latched 68000 handshake option |
| byte_swap | output | 1 | Latched byte-swap option |
| hs_oe | output | 1 | Handshake pin output enable |
| hs_val | output | 1 | Handshake pin driven value |

## Verification
The assertions take for granted that the strap pins matter only while reset is high. The checks on the latched flags therefore start on the first cycle after reset. They also take for granted that `xfer_done` needs no qualification from the host: it may pulse at any time, inside a cycle or outside one. The stimulus holds the bus inputs for one to six cycles at a time, so that cycles last long enough to reach the ready, release and acknowledge states. It drives `xfer_done` at random on every cycle, and it scrambles the strap pins after every reset.

// File: rtl/strap_bus_pkg.sv
package strap_bus_pkg;

  localparam int IO_KEY_W  = 9;
  localparam int MEM_KEY_W = 3;
  localparam int FLAG_W    = 4;
  localparam int STRAP_W   = MEM_KEY_W + IO_KEY_W + FLAG_W;

  // Field order matches the strap pin numbering: bus16 is pin 0.
  typedef struct packed {
    logic [MEM_KEY_W-1:0] mem_key;
    logic [IO_KEY_W-1:0]  io_key;
    logic                 swap;
    logic                 m68k;
    logic                 direct;
    logic                 bus16;
  } strap_t;

  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_BUSY = 2'd1,
    HS_REL  = 2'd2,
    HS_DONE = 2'd3
  } hs_state_e;

  // A cycle is in progress: the address strobe in 68000 mode,
  // otherwise either of the read and write strobes.
  function automatic logic strobe_active(input logic m68k, input logic as_n,
                                         input logic rd_n, input logic wr_n);
    return m68k ? !as_n : (!rd_n || !wr_n);
  endfunction

  // Next handshake state for the current cycle.
  function automatic hs_state_e hs_next(input hs_state_e cur, input logic hit,
                                        input logic done, input logic m68k);
    hs_state_e nx;
    if (!hit) begin
      nx = HS_IDLE;
    end else begin
      unique case (cur)
        HS_IDLE: nx = HS_BUSY;
        HS_BUSY: nx = done ? (m68k ? HS_DONE : HS_REL) : HS_BUSY;
        default: nx = HS_DONE;
      endcase
    end
    return nx;
  endfunction

endpackage

// File: rtl/strap_latch.sv
module strap_latch
  import strap_bus_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [STRAP_W-1:0] strap_pins,
  output strap_t             straps
);

  strap_t strap_q;

  // Loads on every edge during reset; the last load before release is kept.
  always_ff @(posedge clk) begin
    if (rst) begin
      strap_q <= strap_t'(strap_pins);
    end
  end

  assign straps = strap_q;

endmodule

// File: rtl/strap_cycle_decode.sv
module strap_cycle_decode
  import strap_bus_pkg::*;
(
  input  strap_t               straps,
  input  logic [IO_KEY_W-1:0]  io_addr,
  input  logic [MEM_KEY_W-1:0] mem_addr,
  input  logic                 io_cs_n,
  input  logic                 mem_cs_n,
  input  logic                 io_rd_n,
  input  logic                 io_wr_n,
  input  logic                 mem_rd_n,
  input  logic                 mem_wr_n,
  output logic                 io_hit,
  output logic                 mem_hit
);

  logic io_act;
  logic mem_act;
  logic io_key_eq;
  logic mem_key_eq;
  logic unused_flags;

  assign unused_flags = ^{straps.swap, straps.direct, straps.bus16};

  always_comb begin
    io_act     = strobe_active(straps.m68k, io_rd_n, io_rd_n, io_wr_n);
    mem_act    = strobe_active(straps.m68k, io_rd_n, mem_rd_n, mem_wr_n);
    io_key_eq  = (io_addr == straps.io_key);
    mem_key_eq = (mem_addr == straps.mem_key);
    io_hit     = !io_cs_n && io_act && io_key_eq;
    mem_hit    = !mem_cs_n && mem_act && mem_key_eq;
  end

endmodule

// File: rtl/strap_hs_ctrl.sv
module strap_hs_ctrl
  import strap_bus_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic m68k,
  input  logic io_hit,
  input  logic mem_hit,
  input  logic xfer_done,
  output logic reg_sel,
  output logic mem_sel,
  output logic hs_oe,
  output logic hs_val
);

  hs_state_e st_q;
  hs_state_e st_nx;
  logic      any_hit;

  assign any_hit = io_hit || mem_hit;

  always_comb begin
    st_nx = hs_next(st_q, any_hit, xfer_done, m68k);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= HS_IDLE;
      reg_sel <= 1'b0;
      mem_sel <= 1'b0;
    end else begin
      st_q    <= st_nx;
      reg_sel <= io_hit;
      mem_sel <= mem_hit;
    end
  end

  // Ready: low while the transfer is pending, high for one release cycle.
  // Acknowledge: low once the transfer is done.
  always_comb begin
    if (m68k) begin
      hs_oe  = (st_q == HS_DONE);
      hs_val = 1'b0;
    end else begin
      hs_oe  = (st_q == HS_BUSY) || (st_q == HS_REL);
      hs_val = (st_q == HS_REL);
    end
  end

endmodule

// File: rtl/strap_bus_decoder.sv
module strap_bus_decoder
  import strap_bus_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [STRAP_W-1:0] strap_pins,
  input  logic [ADDR_W-1:0]  host_addr,
  input  logic               io_cs_n,
  input  logic               mem_cs_n,
  input  logic               io_rd_n,
  input  logic               io_wr_n,
  input  logic               mem_rd_n,
  input  logic               mem_wr_n,
  input  logic               xfer_done,
  output logic               reg_sel,
  output logic               mem_sel,
  output logic               bus16,
  output logic               direct_map,
  output logic               m68k_mode,
  output logic               byte_swap,
  output logic               hs_oe,
  output logic               hs_val
);

  localparam int IO_LSB  = 1;
  localparam int IO_MSB  = IO_LSB + IO_KEY_W - 1;
  localparam int MEM_LSB = ADDR_W - MEM_KEY_W;

  strap_t                straps;
  logic [IO_KEY_W-1:0]   io_addr;
  logic [MEM_KEY_W-1:0]  mem_addr;
  logic                  io_hit;
  logic                  mem_hit;
  logic                  unused_addr;

  assign io_addr     = host_addr[IO_MSB:IO_LSB];
  assign mem_addr    = host_addr[ADDR_W-1:MEM_LSB];
  assign unused_addr = ^{host_addr[MEM_LSB-1:IO_MSB+1], host_addr[IO_LSB-1:0]};

  strap_latch u_latch (
    .clk        (clk),
    .rst        (rst),
    .strap_pins (strap_pins),
    .straps     (straps)
  );

  strap_cycle_decode u_decode (
    .straps   (straps),
    .io_addr  (io_addr),
    .mem_addr (mem_addr),
    .io_cs_n  (io_cs_n),
    .mem_cs_n (mem_cs_n),
    .io_rd_n  (io_rd_n),
    .io_wr_n  (io_wr_n),
    .mem_rd_n (mem_rd_n),
    .mem_wr_n (mem_wr_n),
    .io_hit   (io_hit),
    .mem_hit  (mem_hit)
  );

  strap_hs_ctrl u_hs (
    .clk       (clk),
    .rst       (rst),
    .m68k      (straps.m68k),
    .io_hit    (io_hit),
    .mem_hit   (mem_hit),
    .xfer_done (xfer_done),
    .reg_sel   (reg_sel),
    .mem_sel   (mem_sel),
    .hs_oe     (hs_oe),
    .hs_val    (hs_val)
  );

  assign bus16      = straps.bus16;
  assign direct_map = straps.direct;
  assign m68k_mode  = straps.m68k;
  assign byte_swap  = straps.swap;

endmodule

// File: rtl/strap_bus_decoder_chk.sv
module strap_bus_decoder_chk
  import strap_bus_pkg::*;
(
  input logic                 clk,
  input logic                 rst,
  input strap_t               straps,
  input logic [IO_KEY_W-1:0]  io_addr,
  input logic [MEM_KEY_W-1:0] mem_addr,
  input logic                 io_cs_n,
  input logic                 mem_cs_n,
  input logic                 xfer_done,
  input logic                 reg_sel,
  input logic                 mem_sel,
  input logic                 hs_oe,
  input logic                 hs_val
);

  AST_STRAPS_HELD: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(straps)); // R2

  AST_IO_KEY_MATCH: assert property (@(posedge clk) disable iff (rst)
    reg_sel |-> ($past(io_addr) == straps.io_key)); // R3

  AST_MEM_KEY_MATCH: assert property (@(posedge clk) disable iff (rst)
    mem_sel |-> ($past(mem_addr) == straps.mem_key)); // R4

  AST_IO_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
    $past(io_cs_n) |-> !reg_sel); // R5

  AST_MEM_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
    $past(mem_cs_n) |-> !mem_sel); // R5

  AST_READY_ONE_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (!straps.m68k && hs_oe && hs_val) |=> !(hs_oe && hs_val)); // R8

  AST_ACK_DRIVES_LOW: assert property (@(posedge clk) disable iff (rst)
    (straps.m68k && hs_oe) |-> !hs_val); // R9

  AST_ACK_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    (straps.m68k && $rose(hs_oe)) |-> $past(xfer_done)); // R9

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    !(reg_sel || mem_sel) |-> !hs_oe); // R10

endmodule

bind strap_bus_decoder strap_bus_decoder_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .straps    (straps),
  .io_addr   (io_addr),
  .mem_addr  (mem_addr),
  .io_cs_n   (io_cs_n),
  .mem_cs_n  (mem_cs_n),
  .xfer_done (xfer_done),
  .reg_sel   (reg_sel),
  .mem_sel   (mem_sel),
  .hs_oe     (hs_oe),
  .hs_val    (hs_val)
);

// File: tb/strap_bus_decoder_bench.sv
module strap_bus_decoder_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] strap_pins = '0;
  logic [19:0] host_addr = '0;
  logic        io_cs_n = 1'b1, mem_cs_n = 1'b1;
  logic        io_rd_n = 1'b1, io_wr_n = 1'b1;
  logic        mem_rd_n = 1'b1, mem_wr_n = 1'b1;
  logic        xfer_done = 1'b0;
  logic        reg_sel, mem_sel, bus16, direct_map, m68k_mode, byte_swap;
  logic        hs_oe, hs_val;

  int checks = 0;
  int fails = 0;
  bit run_done = 0;
  int m_st = 0;             // 0 idle, 1 pending, 2 release, 3 acknowledged
  logic [15:0] cur_s = '0;

  always #5 clk = ~clk;

  strap_bus_decoder u_strap_bus_decoder (
    .clk(clk), .rst(rst), .strap_pins(strap_pins), .host_addr(host_addr),
    .io_cs_n(io_cs_n), .mem_cs_n(mem_cs_n), .io_rd_n(io_rd_n), .io_wr_n(io_wr_n),
    .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .xfer_done(xfer_done),
    .reg_sel(reg_sel), .mem_sel(mem_sel), .bus16(bus16), .direct_map(direct_map),
    .m68k_mode(m68k_mode), .byte_swap(byte_swap), .hs_oe(hs_oe), .hs_val(hs_val)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic f_io(input logic [15:0] s, input logic [19:0] a,
                                input logic cs, input logic rd, input logic wr);
    logic act;
    act = s[2] ? !rd : (!rd || !wr);
    return !cs && act && (a[9:1] == s[12:4]);
  endfunction

  function automatic logic f_mem(input logic [15:0] s, input logic [19:0] a,
                                 input logic cs, input logic as_n,
                                 input logic rd, input logic wr);
    logic act;
    act = s[2] ? !as_n : (!rd || !wr);
    return !cs && act && (a[19:17] == s[15:13]);
  endfunction

  function automatic int f_next(input int st, input logic hit, input logic done,
                                input logic m68k);
    if (!hit) return 0;
    if (st == 0) return 1;
    if (st == 1) return done ? (m68k ? 3 : 2) : 1;
    return 3;
  endfunction

  task automatic bus_idle();
    io_cs_n = 1; mem_cs_n = 1; io_rd_n = 1; io_wr_n = 1;
    mem_rd_n = 1; mem_wr_n = 1; xfer_done = 0;
  endtask

  task automatic check_outputs(input string tag, input logic e_io, input logic e_mem,
                               input int st, input logic m68k);
    logic e_oe, e_val;
    e_oe  = m68k ? (st == 3) : (st == 1 || st == 2);
    e_val = (!m68k && st == 2);
    chk({tag, " R3 R4 R7 reg_sel"}, reg_sel, e_io);
    chk({tag, " R4 R7 mem_sel"}, mem_sel, e_mem);
    chk({tag, " R8 R9 R10 hs_oe"}, hs_oe, e_oe);
    if (e_oe) chk({tag, " R8 R9 hs_val"}, hs_val, e_val);
  endtask

  task automatic do_reset(input logic [15:0] s);
    @(negedge clk);
    rst = 1; strap_pins = s;
    // An active matching cycle during reset must not get through (R1).
    host_addr = {s[15:13], 7'd0, s[12:4], 1'b0};
    io_cs_n = 0; io_rd_n = 0; mem_cs_n = 0; mem_rd_n = 0; xfer_done = 1;
    repeat (3) @(negedge clk);
    chk("R1 reg_sel in reset", reg_sel, 0);
    chk("R1 mem_sel in reset", mem_sel, 0);
    chk("R1 hs_oe in reset", hs_oe, 0);
    bus_idle();
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    strap_pins = ~s;
    chk("R1 reg_sel after release", reg_sel, 0);
    chk("R1 hs_oe after release", hs_oe, 0);
    @(negedge clk);
    chk("R2 flags held", {28'd0, byte_swap, m68k_mode, direct_map, bus16}, {28'd0, s[3:0]});
    strap_pins = $urandom();
    m_st = 0; cur_s = s;
  endtask

  task automatic run_random(input int n);
    int hold = 0;
    for (int i = 0; i < n; i++) begin
      logic e_io, e_mem;
      int nx;
      if (hold == 0) begin
        host_addr = $urandom();
        if ($urandom_range(0, 1) == 1) host_addr[9:1] = cur_s[12:4];
        if ($urandom_range(0, 1) == 1) host_addr[19:17] = cur_s[15:13];
        io_cs_n  = $urandom_range(0, 1);
        mem_cs_n = $urandom_range(0, 1);
        io_rd_n  = $urandom_range(0, 1);
        io_wr_n  = $urandom_range(0, 1);
        mem_rd_n = $urandom_range(0, 1);
        mem_wr_n = $urandom_range(0, 1);
        hold = $urandom_range(1, 6);
      end
      hold--;
      xfer_done = ($urandom_range(0, 3) == 0);
      e_io  = f_io(cur_s, host_addr, io_cs_n, io_rd_n, io_wr_n);
      e_mem = f_mem(cur_s, host_addr, mem_cs_n, io_rd_n, mem_rd_n, mem_wr_n);
      nx = f_next(m_st, e_io || e_mem, xfer_done, cur_s[2]);
      @(negedge clk);
      check_outputs("rand R5 R6", e_io, e_mem, nx, cur_s[2]);
      m_st = nx;
    end
    bus_idle();
    @(negedge clk);
    m_st = 0;
  endtask

  // Wait mode, directed: strobe qualification, bit 0 ignored, ready sequence.
  task automatic directed_wait();
    host_addr = {cur_s[15:13], 7'd0, cur_s[12:4], 1'b1};
    io_cs_n = 0;
    @(negedge clk);
    chk("R5 no strobe no select", reg_sel, 0);
    io_wr_n = 0;
    @(negedge clk);
    chk("R3 addr bit0 ignored", reg_sel, 1);
    chk("R8 ready driven low", {hs_oe, hs_val}, 2'b10);
    @(negedge clk);
    chk("R8 still low while pending", {hs_oe, hs_val}, 2'b10);
    xfer_done = 1;
    @(negedge clk);
    xfer_done = 0;
    chk("R8 release pulse high", {hs_oe, hs_val}, 2'b11);
    @(negedge clk);
    chk("R8 released after pulse", hs_oe, 0);
    chk("R7 select holds for cycle", reg_sel, 1);
    host_addr[9] = ~host_addr[9];
    @(negedge clk);
    chk("R3 key mismatch", reg_sel, 0);
    bus_idle();
    xfer_done = 1;
    @(negedge clk);
    chk("R10 done outside cycle", hs_oe, 0);
    xfer_done = 0;
    @(negedge clk);
    m_st = 0;
  endtask

  // 68000 mode, directed: memory strobes ignored, acknowledge after done.
  task automatic directed_m68k();
    host_addr = {cur_s[15:13], 7'd0, cur_s[12:4], 1'b0};
    mem_cs_n = 0; mem_rd_n = 0; mem_wr_n = 0; io_rd_n = 1;
    @(negedge clk);
    chk("R6 memory strobes ignored", mem_sel, 0);
    io_rd_n = 0;
    @(negedge clk);
    chk("R6 address strobe selects", mem_sel, 1);
    chk("R9 no ack before done", hs_oe, 0);
    xfer_done = 1;
    @(negedge clk);
    xfer_done = 0;
    chk("R9 ack driven low", {hs_oe, hs_val}, 2'b10);
    @(negedge clk);
    chk("R9 ack held to cycle end", {hs_oe, hs_val}, 2'b10);
    io_rd_n = 1;
    @(negedge clk);
    chk("R9 ack released at cycle end", hs_oe, 0);
    bus_idle();
    @(negedge clk);
    m_st = 0;
  endtask

  initial begin
    void'($urandom(32'h5eed_1357));
    do_reset(16'h0000);
    directed_wait();
    run_random(400);
    do_reset({3'b101, 9'h15a, 4'b1011});
    directed_wait();
    run_random(400);
    do_reset({3'b011, 9'h0c3, 4'b0100});
    directed_m68k();
    run_random(400);
    for (int e = 0; e < 4; e++) begin
      do_reset(16'($urandom()));
      run_random(500);
    end
    run_done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!run_done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule